// File: doc/BRIEF.md
# Channel Charge Summary Unit

This block condenses one sample from each of 48 charge channels into a summary word for the next trigger level. The word holds the total charge of all channels, the largest single-channel charge, the channel that holds it, and a flag that is raised when any channel sits at its full-scale code. The channels are also grouped into fixed patches of adjacent channels. The block outputs each patch's partial sum and reports the lowest-numbered patch whose sum is above a programmable minimum.

All summary fields leave through one pipeline with a fixed latency and a single output valid strobe. The block can therefore take a new sample on every clock. Next to the pipeline, every channel has a saturating rate counter. It counts the samples in which the channel rises from below a programmable threshold to at or above it. A clear pulse resets all the counters.

Top module: `charge_summary_unit`

## Requirements
- R1: `sum_o` equals the unsigned sum of all 48 channel samples. It is 16 bits wide, so 48 full-scale inputs (49104) do not overflow.
- R2: `max_o` equals the largest channel sample.
- R3: `max_idx_o` is the index (0 to 47) of the channel that holds the maximum. When several channels tie, the lowest index is reported. Channel c occupies `chan_i[c*10 +: 10]`.
- R4: `sat_o` is 1 exactly when at least one channel sample equals the full-scale code 1023.
- R5: Patch p is made of channels 4p to 4p+3, which gives 12 patches. Its 12-bit sum appears at `patch_sums_o[p*12 +: 12]`.
- R6: `patch_hit_o` is 1 when some patch sum is strictly greater than `patch_thr_i`. `patch_idx_o` then gives the lowest such patch. When no patch exceeds the threshold, `patch_idx_o` is 0. The threshold used is the one presented with the sample.
- R7: `valid_o` rises exactly 7 clock edges after `valid_i` is sampled high, counting the sampling edge. All summary fields present that same sample while `valid_o` is high.
- R8: The counter for channel c sits at `rate_cnt_o[c*16 +: 16]`. It increments on a valid sample that is at or above `rate_thr_i` when the previous valid sample was below it. The first valid sample after reset or clear counts if it is at or above the threshold. The counter holds at 65535.
- R9: `rate_clr_i` zeroes every counter and its crossing history on the next edge. It overrides a crossing in the same cycle.
- R10: While `rst_ni` is low, `valid_o` is 0 and all rate counters read 0.
- R11: Samples with `valid_i` low change neither the rate counters nor their crossing history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Sample present on chan_i |
| chan_i | input | 480 | 48 packed 10-bit channel samples |
| patch_thr_i | input | 12 | Patch minimum threshold |
| rate_thr_i | input | 10 | Rate counter threshold |
| rate_clr_i | input | 1 | Clear all rate counters |
| valid_o | output | 1 | Summary word valid |
| sum_o | output | 16 | Total charge |
| max_o | output | 10 | Largest channel charge |
| max_idx_o | output | 6 | Channel index of the maximum |
| sat_o | output | 1 | Any channel at full scale |
| patch_sums_o | output | 144 | 12 packed patch sums |
| patch_hit_o | output | 1 | Some patch above threshold |
| patch_idx_o | output | 4 | Lowest patch above threshold |
| rate_cnt_o | output | 768 | 48 packed 16-bit rate counters |

## Verification
The hardest state to reach from the ports is a rate counter pinned at 65535. It takes more than 131000 valid samples that swing alternately above and below the threshold. The stimulus therefore spends most of the run toggling every channel between 0 and full scale, and checks that the counters stop at the ceiling. Ties for the maximum and a patch sum exactly equal to the threshold are set up on purpose, so that the lowest-index rule and the strict comparison are both tested. Idle cycles with changing data are placed between valid samples, and a clear is issued in the same cycle as a crossing.

// File: rtl/csu_pkg.sv
package csu_pkg;
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/csu_delay.sv
module csu_delay #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[DEPTH-1];
endmodule

// File: rtl/csu_add_tree.sv
// Heap-ordered adder tree, one register per level; leaves are combinational.
module csu_add_tree #(
  parameter int N     = 48,
  parameter int IN_W  = 10,
  parameter int OUT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N*IN_W-1:0] leaf_i,
  output logic [OUT_W-1:0]  sum_o
);
  localparam int LV = csu_pkg::idx_bits(N);
  localparam int P  = 1 << LV;

  logic [OUT_W-1:0] node [P-1];
  logic [OUT_W-1:0] tree [2*P-1];

  for (genvar h = 0; h < 2*P-1; h++) begin : g_map
    if (h < P-1) begin : g_int
      assign tree[h] = node[h];
    end else if (h - (P-1) < N) begin : g_leaf
      assign tree[h] = OUT_W'(leaf_i[(h-(P-1))*IN_W +: IN_W]);
    end else begin : g_pad
      assign tree[h] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int h = 0; h < P-1; h++) node[h] <= '0;
    end else begin
      for (int h = 0; h < P-1; h++) node[h] <= tree[2*h+1] + tree[2*h+2];
    end
  end

  assign sum_o = node[0];
endmodule

// File: rtl/csu_max_tree.sv
// Heap-ordered argmax tree; the left (lower index) child wins ties.
module csu_max_tree #(
  parameter int N    = 48,
  parameter int IN_W = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N*IN_W-1:0]             leaf_i,
  output logic [IN_W-1:0]               max_o,
  output logic [csu_pkg::idx_bits(N)-1:0] idx_o
);
  localparam int LV = csu_pkg::idx_bits(N);
  localparam int P  = 1 << LV;

  logic [IN_W-1:0] node_v [P-1];
  logic [LV-1:0]   node_i [P-1];
  logic [IN_W-1:0] tree_v [2*P-1];
  logic [LV-1:0]   tree_i [2*P-1];

  for (genvar h = 0; h < 2*P-1; h++) begin : g_map
    if (h < P-1) begin : g_int
      assign tree_v[h] = node_v[h];
      assign tree_i[h] = node_i[h];
    end else if (h - (P-1) < N) begin : g_leaf
      assign tree_v[h] = leaf_i[(h-(P-1))*IN_W +: IN_W];
      assign tree_i[h] = LV'(h - (P-1));
    end else begin : g_pad
      assign tree_v[h] = '0;
      assign tree_i[h] = LV'(h - (P-1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int h = 0; h < P-1; h++) begin
        node_v[h] <= '0;
        node_i[h] <= '0;
      end
    end else begin
      for (int h = 0; h < P-1; h++) begin
        if (tree_v[2*h+1] >= tree_v[2*h+2]) begin
          node_v[h] <= tree_v[2*h+1];
          node_i[h] <= tree_i[2*h+1];
        end else begin
          node_v[h] <= tree_v[2*h+2];
          node_i[h] <= tree_i[2*h+2];
        end
      end
    end
  end

  assign max_o = node_v[0];
  assign idx_o = node_i[0];
endmodule

// File: rtl/csu_rate_cnt.sv
module csu_rate_cnt #(
  parameter int CH_W  = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             valid_i,
  input  logic [CH_W-1:0]  sample_i,
  input  logic [CH_W-1:0]  thr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             above_q;
  logic             above;

  assign above = (sample_i >= thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      above_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      above_q <= 1'b0;
    end else if (valid_i) begin
      above_q <= above;
      if (above && !above_q && (cnt_q != '1)) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  AST_RATE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))); // R8
  AST_RATE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R9
  AST_RATE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/charge_summary_unit.sv
module charge_summary_unit #(
  parameter int N_CH     = 48,
  parameter int CH_W     = 10,
  parameter int PATCH_SZ = 4,
  parameter int RATE_W   = 16,
  localparam int LV      = csu_pkg::idx_bits(N_CH),
  localparam int SUM_W   = CH_W + LV,
  localparam int N_PATCH = N_CH / PATCH_SZ,
  localparam int PSUM_W  = CH_W + csu_pkg::idx_bits(PATCH_SZ),
  localparam int PIDX_W  = csu_pkg::idx_bits(N_PATCH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [N_CH*CH_W-1:0]        chan_i,
  input  logic [PSUM_W-1:0]           patch_thr_i,
  input  logic [CH_W-1:0]             rate_thr_i,
  input  logic                        rate_clr_i,
  output logic                        valid_o,
  output logic [SUM_W-1:0]            sum_o,
  output logic [CH_W-1:0]             max_o,
  output logic [LV-1:0]               max_idx_o,
  output logic                        sat_o,
  output logic [N_PATCH*PSUM_W-1:0]   patch_sums_o,
  output logic                        patch_hit_o,
  output logic [PIDX_W-1:0]           patch_idx_o,
  output logic [N_CH*RATE_W-1:0]      rate_cnt_o
);
  localparam int LAT = LV + 1;
  localparam logic [CH_W-1:0] FULL = '1;

  // stage 0: input capture
  logic [N_CH*CH_W-1:0] in_q;
  logic [PSUM_W-1:0]    thr_q0, thr_q1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      thr_q0 <= '0;
    end else begin
      in_q   <= chan_i;
      thr_q0 <= patch_thr_i;
    end
  end

  csu_delay #(.WIDTH(1), .DEPTH(LAT)) u_vld (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(valid_i), .q_o(valid_o));

  csu_add_tree #(.N(N_CH), .IN_W(CH_W), .OUT_W(SUM_W)) u_sum (
    .clk_i(clk_i), .rst_ni(rst_ni), .leaf_i(in_q), .sum_o(sum_o));

  csu_max_tree #(.N(N_CH), .IN_W(CH_W)) u_max (
    .clk_i(clk_i), .rst_ni(rst_ni), .leaf_i(in_q), .max_o(max_o), .idx_o(max_idx_o));

  // stage 1: saturation OR and patch partial sums
  logic                      sat_c, sat_q1;
  logic [N_PATCH*PSUM_W-1:0] psum_c, psum_q1;

  always_comb begin
    sat_c = 1'b0;
    for (int c = 0; c < N_CH; c++) sat_c |= (in_q[c*CH_W +: CH_W] == FULL);
  end

  always_comb begin
    psum_c = '0;
    for (int p = 0; p < N_PATCH; p++) begin
      logic [PSUM_W-1:0] acc;
      acc = '0;
      for (int k = 0; k < PATCH_SZ; k++)
        acc += PSUM_W'(in_q[(p*PATCH_SZ+k)*CH_W +: CH_W]);
      psum_c[p*PSUM_W +: PSUM_W] = acc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sat_q1  <= 1'b0;
      psum_q1 <= '0;
      thr_q1  <= '0;
    end else begin
      sat_q1  <= sat_c;
      psum_q1 <= psum_c;
      thr_q1  <= thr_q0;
    end
  end

  // stage 2: lowest patch above threshold
  logic              hit_c, hit_q2;
  logic [PIDX_W-1:0] pidx_c, pidx_q2;

  always_comb begin
    hit_c  = 1'b0;
    pidx_c = '0;
    for (int p = N_PATCH-1; p >= 0; p--) begin
      if (psum_q1[p*PSUM_W +: PSUM_W] > thr_q1) begin
        hit_c  = 1'b1;
        pidx_c = PIDX_W'(p);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q2  <= 1'b0;
      pidx_q2 <= '0;
    end else begin
      hit_q2  <= hit_c;
      pidx_q2 <= pidx_c;
    end
  end

  // align side paths with the tree outputs
  csu_delay #(.WIDTH(1), .DEPTH(LV-1)) u_sat_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sat_q1), .q_o(sat_o));

  csu_delay #(.WIDTH(N_PATCH*PSUM_W), .DEPTH(LV-1)) u_psum_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(psum_q1), .q_o(patch_sums_o));

  csu_delay #(.WIDTH(PIDX_W+1), .DEPTH(LV-2)) u_hit_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({hit_q2, pidx_q2}), .q_o({patch_hit_o, patch_idx_o}));

  // per-channel rate counters on the raw input
  for (genvar c = 0; c < N_CH; c++) begin : g_rate
    csu_rate_cnt #(.CH_W(CH_W), .CNT_W(RATE_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (rate_clr_i),
      .valid_i (valid_i),
      .sample_i(chan_i[c*CH_W +: CH_W]),
      .thr_i   (rate_thr_i),
      .cnt_o   (rate_cnt_o[c*RATE_W +: RATE_W]));
  end

  AST_SUM_GE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sum_o >= SUM_W'(max_o))); // R1
  AST_SAT_IS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sat_o) |-> (max_o == FULL)); // R4
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({1'b0, max_idx_o} < (LV+1)'(N_CH))); // R3
  AST_PATCH_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !patch_hit_o) |-> (patch_idx_o == '0)); // R6
  AST_PATCH_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({1'b0, patch_idx_o} < (PIDX_W+1)'(N_PATCH))); // R6
endmodule

// File: tb/sim_charge_summary_unit.sv
`timescale 1ns/1ps
module sim_charge_summary_unit;
  localparam int N = 48, W = 10, PS = 4, NP = 12, PSW = 12, RW = 16, LAT = 7;

  logic clk = 0, rst_n = 0;
  logic valid_i = 0, rate_clr_i = 0;
  logic [N*W-1:0] chan_i = '0;
  logic [PSW-1:0] patch_thr_i = '0;
  logic [W-1:0] rate_thr_i = '0;
  logic valid_o, sat_o, patch_hit_o;
  logic [15:0] sum_o;
  logic [W-1:0] max_o;
  logic [5:0] max_idx_o;
  logic [NP*PSW-1:0] patch_sums_o;
  logic [3:0] patch_idx_o;
  logic [N*RW-1:0] rate_cnt_o;

  always #2 clk = ~clk;

  charge_summary_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .chan_i(chan_i),
    .patch_thr_i(patch_thr_i), .rate_thr_i(rate_thr_i), .rate_clr_i(rate_clr_i),
    .valid_o(valid_o), .sum_o(sum_o), .max_o(max_o), .max_idx_o(max_idx_o),
    .sat_o(sat_o), .patch_sums_o(patch_sums_o), .patch_hit_o(patch_hit_o),
    .patch_idx_o(patch_idx_o), .rate_cnt_o(rate_cnt_o));

  int n_vec = 0, n_fail = 0;
  bit done = 0;
  int ch [N];
  int pthr = 0, rthr = 0;
  bit vin = 0, clr = 0;
  string rate_tag = "R8";

  // reference pipeline, stage 0 = newest sample
  bit e_v [LAT]; int e_sum [LAT]; int e_mx [LAT]; int e_mi [LAT];
  bit e_sat [LAT]; int e_ps [LAT][NP]; bit e_hit [LAT]; int e_pi [LAT];
  int r_cnt [N]; bit r_prev [N];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < LAT; s++) begin
      e_v[s] = 0; e_sum[s] = 0; e_mx[s] = 0; e_mi[s] = 0; e_sat[s] = 0;
      e_hit[s] = 0; e_pi[s] = 0;
      for (int p = 0; p < NP; p++) e_ps[s][p] = 0;
    end
    for (int c = 0; c < N; c++) begin r_cnt[c] = 0; r_prev[c] = 0; end
  endtask

  task automatic cycle();
    for (int c = 0; c < N; c++) chan_i[c*W +: W] = W'(ch[c]);
    valid_i = vin; rate_clr_i = clr;
    patch_thr_i = PSW'(pthr); rate_thr_i = W'(rthr);
    @(posedge clk); #1;
    for (int s = LAT-1; s > 0; s--) begin
      e_v[s] = e_v[s-1]; e_sum[s] = e_sum[s-1]; e_mx[s] = e_mx[s-1]; e_mi[s] = e_mi[s-1];
      e_sat[s] = e_sat[s-1]; e_hit[s] = e_hit[s-1]; e_pi[s] = e_pi[s-1];
      for (int p = 0; p < NP; p++) e_ps[s][p] = e_ps[s-1][p];
    end
    e_v[0] = vin; e_sum[0] = 0; e_mx[0] = -1; e_mi[0] = 0; e_sat[0] = 0;
    e_hit[0] = 0; e_pi[0] = 0;
    for (int c = 0; c < N; c++) begin
      e_sum[0] += ch[c];
      if (ch[c] > e_mx[0]) begin e_mx[0] = ch[c]; e_mi[0] = c; end
      if (ch[c] == 1023) e_sat[0] = 1;
    end
    for (int p = 0; p < NP; p++) begin
      e_ps[0][p] = ch[4*p] + ch[4*p+1] + ch[4*p+2] + ch[4*p+3];
      if (!e_hit[0] && e_ps[0][p] > pthr) begin e_hit[0] = 1; e_pi[0] = p; end
    end
    if (clr) begin
      for (int c = 0; c < N; c++) begin r_cnt[c] = 0; r_prev[c] = 0; end
    end else if (vin) begin
      for (int c = 0; c < N; c++) begin
        bit ab;
        ab = (ch[c] >= rthr);
        if (ab && !r_prev[c] && r_cnt[c] < 65535) r_cnt[c]++;
        r_prev[c] = ab;
      end
    end
    // compare
    check(valid_o == e_v[LAT-1], "R7 valid_o", valid_o, e_v[LAT-1]);
    if (e_v[LAT-1]) begin
      check(sum_o == e_sum[LAT-1], "R1 sum", sum_o, e_sum[LAT-1]);
      check(max_o == e_mx[LAT-1], "R2 max", max_o, e_mx[LAT-1]);
      check(max_idx_o == e_mi[LAT-1], "R3 max_idx", max_idx_o, e_mi[LAT-1]);
      check(sat_o == e_sat[LAT-1], "R4 sat", sat_o, e_sat[LAT-1]);
      begin
        int bad; bad = -1;
        for (int p = NP-1; p >= 0; p--)
          if (patch_sums_o[p*PSW +: PSW] != e_ps[LAT-1][p]) bad = p;
        check(bad < 0, "R5 patch sum", bad < 0 ? 0 : patch_sums_o[bad*PSW +: PSW],
              bad < 0 ? 0 : e_ps[LAT-1][bad]);
      end
      check(patch_hit_o == e_hit[LAT-1], "R6 patch_hit", patch_hit_o, e_hit[LAT-1]);
      check(patch_idx_o == e_pi[LAT-1], "R6 patch_idx", patch_idx_o, e_pi[LAT-1]);
    end
    begin
      int bad; bad = -1;
      for (int c = N-1; c >= 0; c--) if (rate_cnt_o[c*RW +: RW] != r_cnt[c]) bad = c;
      check(bad < 0, rate_tag, bad < 0 ? 0 : rate_cnt_o[bad*RW +: RW],
            bad < 0 ? 0 : r_cnt[bad]);
    end
  endtask

  task automatic set_all(input int v);
    for (int c = 0; c < N; c++) ch[c] = v;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1; n_vec++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    set_all(0);
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check(valid_o == 0, "R10 valid_o in reset", valid_o, 0);
    check(rate_cnt_o == '0, "R10 rate counters in reset", rate_cnt_o[RW-1:0], 0);
    rst_n = 1;

    rthr = 300; pthr = 2000;
    vin = 1; set_all(0); cycle();
    // random samples with valid gaps (R11 while idle)
    for (int i = 0; i < 40; i++) begin
      for (int c = 0; c < N; c++) ch[c] = int'($urandom_range(0, 1023));
      vin = (i % 5 != 3);
      rate_tag = vin ? "R8" : "R11";
      cycle();
    end
    rate_tag = "R8"; vin = 1;
    // R3 tie: lowest index wins
    set_all(5); ch[30] = 900; ch[10] = 900; cycle();
    // max at last channel
    set_all(7); ch[47] = 1000; cycle();
    // R4: single saturated channel, then all full scale (R1 max sum)
    set_all(100); ch[20] = 1023; cycle();
    set_all(1023); cycle();
    set_all(1022); cycle();
    // R6: patch 3 sum equals threshold -> no hit; then threshold one lower
    set_all(0); ch[12] = 500; ch[13] = 500; ch[14] = 500; ch[15] = 500; pthr = 2000; cycle();
    pthr = 1999; cycle();
    set_all(0); ch[20] = 700; ch[36] = 700; pthr = 600; cycle();
    set_all(0); pthr = 0; ch[47] = 1; cycle();
    // R9: clear coincides with a crossing
    set_all(0); cycle();
    set_all(1023); clr = 1; rate_tag = "R9"; cycle();
    clr = 0; cycle();
    rate_tag = "R11"; vin = 0;
    for (int i = 0; i < 4; i++) begin set_all(i[0] ? 0 : 1023); cycle(); end
    // drain pipeline
    for (int i = 0; i < LAT + 2; i++) cycle();
    // R8 counter ceiling: alternate below/above threshold
    rate_tag = "R8"; vin = 1; rthr = 512; pthr = 4000;
    for (int i = 0; i < 131200; i++) begin
      set_all(i[0] ? 1023 : 0);
      cycle();
    end
    check(rate_cnt_o[RW-1:0] == 16'hFFFF, "R8 counter saturated", rate_cnt_o[RW-1:0], 65535);
    vin = 0;
    for (int i = 0; i < LAT + 2; i++) cycle();

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule